// File: doc/BRIEF.md
# Multiplexed Bus Cartridge Slave

This block sits on the cartridge side of a 16-bit processor bus. On that bus one set of wires carries both address and data, and a three-wire control code sets the meaning of each bus phase. A fast local clock samples the control code and the bus through two-flop synchronisers. A stability filter discards any control value that does not persist long enough. Such short values appear when the two lower control wires switch a little apart. Each accepted value becomes the current bus state.

When an address-carrying state ends, the block commits the address. There are three such states: plain address, indirect address and interrupt acknowledge. The committed address is compared against a ROM window and, when enabled, against an internal RAM window. During the read-data state the block drives ROM data (taken from `rom_data_i`) or RAM data onto the bus. It writes RAM once at the start of the write-data state. The write-stall state that follows is not used.

Top module: `cart_bus_slave`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is 0 and `bus_oe_o`, `rom_ce_o`, `ram_ce_o`, `rd_o` and `wr_o` are all low.
- R2: Control code `bctl_i` = {dir, c2, c1} decodes as follows: 000 idle, 001 indirect address, 010 interrupt vector, 011 read data, 100 address, 101 write data, 110 write stall, 111 interrupt acknowledge. The bus value seen during an address (100) state appears on `addr_o` once that state ends.
- R3: The bus value seen during an indirect-address (001) state appears on `addr_o` once that state ends.
- R4: The bus value seen during an interrupt-acknowledge (111) state appears on `addr_o` once that state ends, and a write transaction that follows it uses that address.
- R5: A control value held for fewer than `FILT_LEN` (default 4) fast-clock samples is ignored: a 3-sample indirect-address pulse leaves `addr_o` unchanged. A 4-sample pulse is accepted and latches.
- R6: In the read-data state, when `addr_o` is in the ROM window (default 0x1000 to 0x1FFF, which includes the reset vector fetch at 0x1000), `bus_oe_o`, `rd_o` and `rom_ce_o` are high and `bus_o` equals `rom_data_i`.
- R7: When `addr_o` is outside both windows, `bus_oe_o`, `rom_ce_o` and `ram_ce_o` stay low through the read-data state.
- R8: A write to the RAM window (default 0x8000 to 0x80FF) gives exactly one `wr_o` pulse and stores the value seen in the write-data state. A later read returns that value on `bus_o`.
- R9: A different bus value in the write-stall (110) state does not change the stored RAM word.
- R10: A write transaction to a ROM-window address gives no `wr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bctl_i | input | 3 | Bus control code {dir, c2, c1} |
| bus_i | input | 16 | Multiplexed address/data bus, input side |
| bus_o | output | 16 | Read data for the bus |
| bus_oe_o | output | 1 | Bus driver enable |
| addr_o | output | 16 | Committed bus address |
| rom_data_i | input | 16 | Data word from the external ROM at `addr_o` |
| rom_ce_o | output | 1 | ROM chip enable |
| ram_ce_o | output | 1 | RAM chip enable |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | One-cycle RAM write strobe |

## Verification
Two things can happen close together: the filter rejecting a skew glitch, and the start of a real read-data state. The bench provokes this by placing a two-sample false indirect-address code, carrying a foreign bus value, directly before a read-data state. It judges the result by checking two things. First, `addr_o` must still hold the address from the earlier address phase and not the glitch value. Second, the read-data state must still enable the bus with the correct window data. The writes that precede these reads go through a reference memory model, so an address corrupted by a glitch would show up as a data mismatch.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'b000,
    ST_IND_ADDR = 3'b001,
    ST_IRQ_VEC  = 3'b010,
    ST_RD_DATA  = 3'b011,
    ST_ADDR     = 3'b100,
    ST_WR_DATA  = 3'b101,
    ST_WR_STALL = 3'b110,
    ST_IRQ_ACK  = 3'b111
  } bus_st_e;

  function automatic logic is_addr_code(logic [2:0] c);
    return (c == ST_ADDR) || (c == ST_IND_ADDR) || (c == ST_IRQ_ACK);
  endfunction
endpackage

// File: rtl/cbs_ctl_filter.sv
module cbs_ctl_filter
  import cbs_pkg::*;
#(
  parameter int DW       = 16,
  parameter int FILT_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    code_i,
  input  logic [DW-1:0] bus_i,
  output logic [2:0]    code_s_o,
  output logic [DW-1:0] bus_s_o,
  output bus_st_e       state_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [2:0]    code_m, code_s, cand_q;
  logic [DW-1:0] bus_m, bus_s;
  logic [CW-1:0] cnt_q;
  bus_st_e       state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_m  <= '0;
      code_s  <= '0;
      bus_m   <= '0;
      bus_s   <= '0;
      cand_q  <= '0;
      cnt_q   <= '0;
      state_q <= ST_IDLE;
    end else begin
      code_m <= code_i;
      code_s <= code_m;
      bus_m  <= bus_i;
      bus_s  <= bus_m;
      if (code_s != cand_q) begin
        cand_q <= code_s;
        cnt_q  <= CW'(1);
      end else if (cnt_q < CW'(FILT_LEN)) begin
        cnt_q <= cnt_q + CW'(1);
      end
      // accept on the FILT_LEN-th consecutive equal sample
      if (code_s == cand_q && cnt_q == CW'(FILT_LEN - 1))
        state_q <= bus_st_e'(cand_q);
    end
  end

  assign code_s_o = code_s;
  assign bus_s_o  = bus_s;
  assign state_o  = state_q;
endmodule

// File: rtl/cbs_addr_latch.sv
module cbs_addr_latch
  import cbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    code_s_i,
  input  logic [DW-1:0] bus_s_i,
  input  bus_st_e       state_i,
  output logic [DW-1:0] addr_o
);
  logic [DW-1:0] shadow_q, addr_q;
  bus_st_e       prev_q;

  // shadow follows the raw code so it still holds phase data after the filter lag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      addr_q   <= '0;
      prev_q   <= ST_IDLE;
    end else begin
      prev_q <= state_i;
      if (is_addr_code(code_s_i)) shadow_q <= bus_s_i;
      if (is_addr_code(prev_q) && !is_addr_code(state_i)) addr_q <= shadow_q;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cbs_ram.sv
module cbs_ram #(
  parameter int DW    = 16,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cart_bus_slave.sv
module cart_bus_slave
  import cbs_pkg::*;
#(
  parameter int DW        = 16,
  parameter int FILT_LEN  = 4,
  parameter int ROM_BASE  = 'h1000,
  parameter int ROM_WORDS = 'h1000,
  parameter bit RAM_EN    = 1'b1,
  parameter int RAM_BASE  = 'h8000,
  parameter int RAM_WORDS = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    bctl_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] addr_o,
  input  logic [DW-1:0] rom_data_i,
  output logic          rom_ce_o,
  output logic          ram_ce_o,
  output logic          rd_o,
  output logic          wr_o
);
  localparam int RAM_AW   = $clog2(RAM_WORDS);
  localparam int ROM_HI_I = ROM_BASE + ROM_WORDS;
  localparam int RAM_HI_I = RAM_BASE + RAM_WORDS;
  localparam logic [DW:0] ROM_LO = ROM_BASE[DW:0];
  localparam logic [DW:0] ROM_HI = ROM_HI_I[DW:0];
  localparam logic [DW:0] RAM_LO = RAM_BASE[DW:0];
  localparam logic [DW:0] RAM_HI = RAM_HI_I[DW:0];

  logic [2:0]    code_s;
  logic [DW-1:0] bus_s, addr_q, ram_rdata;
  bus_st_e       st, prev_st;
  logic          rom_hit, ram_hit, in_rd, in_wr, wr_pulse;

  cbs_ctl_filter #(.DW(DW), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .code_i(bctl_i), .bus_i,
    .code_s_o(code_s), .bus_s_o(bus_s), .state_o(st)
  );

  cbs_addr_latch #(.DW(DW)) u_alat (
    .clk_i, .rst_ni, .code_s_i(code_s), .bus_s_i(bus_s),
    .state_i(st), .addr_o(addr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_st <= ST_IDLE;
    else         prev_st <= st;
  end

  assign rom_hit = ({1'b0, addr_q} >= ROM_LO) && ({1'b0, addr_q} < ROM_HI);
  assign in_rd   = (st == ST_RD_DATA);
  assign in_wr   = (st == ST_WR_DATA);

  generate
    if (RAM_EN) begin : g_ram
      logic [RAM_AW-1:0] ram_idx;
      assign ram_hit = ({1'b0, addr_q} >= RAM_LO) && ({1'b0, addr_q} < RAM_HI);
      assign ram_idx = addr_q[RAM_AW-1:0] - RAM_LO[RAM_AW-1:0];
      cbs_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
        .clk_i, .we_i(wr_pulse), .idx_i(ram_idx),
        .wdata_i(bus_s), .rdata_o(ram_rdata)
      );
    end else begin : g_no_ram
      assign ram_hit   = 1'b0;
      assign ram_rdata = '0;
    end
  endgenerate

  // single write on entry to write-data; the stall state carries nothing new
  assign wr_pulse = in_wr && (prev_st != ST_WR_DATA) && ram_hit;

  assign rom_ce_o = rom_hit && in_rd;
  assign ram_ce_o = ram_hit && (in_rd || in_wr);
  assign rd_o     = in_rd && (rom_hit || ram_hit);
  assign bus_oe_o = rd_o;
  assign bus_o    = !bus_oe_o ? '0 : (rom_hit ? rom_data_i : ram_rdata);
  assign wr_o     = wr_pulse;
  assign addr_o   = addr_q;
endmodule

// File: rtl/cbs_checks.sv
module cbs_checks #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] addr_o,
  input logic          bus_oe_o,
  input logic          rom_ce_o,
  input logic          ram_ce_o,
  input logic          rd_o,
  input logic          wr_o
);
  always @(posedge clk_i) begin
    if (!rst_ni)
      AST_RESET_QUIET: assert (addr_o == '0 && !bus_oe_o && !rom_ce_o && !ram_ce_o && !rd_o && !wr_o)
        else $error("outputs active in reset"); // R1
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (rom_ce_o || ram_ce_o)); // R6

  AST_CE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_ce_o && ram_ce_o)); // R7

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R8

  AST_WR_NOT_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (!rom_ce_o && ram_ce_o && !bus_oe_o)); // R10

  AST_ADDR_HELD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && $past(rd_o)) |-> $stable(addr_o)); // R6
endmodule

bind cart_bus_slave cbs_checks #(.DW(DW)) u_chk (.*);

// File: tb/cart_bus_slave_test.sv
module cart_bus_slave_test;
  localparam int PH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bctl = 3'b000;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out, addr, rom_data;
  logic        oe, rom_ce, ram_ce, rd, wr;
  int checks = 0, fails = 0, wr_cnt = 0;
  logic [15:0] ref_ram [256];

  always #2 clk = ~clk;

  assign rom_data = addr ^ 16'h5A5A;

  cart_bus_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .bctl_i(bctl), .bus_i(bus_in), .bus_o(bus_out),
    .bus_oe_o(oe), .addr_o(addr), .rom_data_i(rom_data), .rom_ce_o(rom_ce),
    .ram_ce_o(ram_ce), .rd_o(rd), .wr_o(wr)
  );

  always @(posedge clk) if (rst_n && wr) wr_cnt++;

  // {kind, glitch, addr, data}; kind 0 rd/addr, 1 rd/indirect, 2 wr/addr, 3 wr/irq-ack
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h1000, 16'h0000},
    {2'd0, 1'b0, 16'h1FFF, 16'h0000},
    {2'd0, 1'b0, 16'h2000, 16'h0000},
    {2'd2, 1'b0, 16'h8000, 16'h1111},
    {2'd0, 1'b1, 16'h8000, 16'h0000},
    {2'd3, 1'b0, 16'h80FF, 16'hBEEF},
    {2'd1, 1'b1, 16'h80FF, 16'h0000},
    {2'd2, 1'b0, 16'h1004, 16'h7777},
    {2'd0, 1'b0, 16'h0FFF, 16'h0000},
    {2'd2, 1'b0, 16'h8100, 16'h2222},
    {2'd1, 1'b0, 16'h1234, 16'h0000}
  };

  function automatic bit rom_hit(logic [15:0] a); return a >= 16'h1000 && a < 16'h2000; endfunction
  function automatic bit ram_hit(logic [15:0] a); return a >= 16'h8000 && a < 16'h8100; endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic phase(input logic [2:0] c, input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bctl = c;
      bus_in = v;
    end
  endtask

  task automatic run_txn(input logic [1:0] kind, input bit gl, input logic [15:0] a, input logic [15:0] d);
    logic [2:0] ac;
    string tag;
    int w0;
    ac  = (kind == 2'd1) ? 3'b001 : (kind == 2'd3) ? 3'b111 : 3'b100;
    tag = (kind == 2'd1) ? "R3" : (kind == 2'd3) ? "R4" : "R2";
    phase(ac, a, PH);
    phase(3'b000, 16'h0000, PH);
    if (kind < 2'd2) begin
      if (gl) phase(3'b001, 16'hDEAD, 2);  // skew glitch just before read data (R5)
      phase(3'b011, 16'h0000, PH);
      #1;
      chk(addr == a, gl ? "R5 glitch kept addr" : tag, addr, a);
      chk(oe == (rom_hit(a) || ram_hit(a)), "R6/R7 oe", {15'd0, oe}, {15'd0, rom_hit(a) || ram_hit(a)});
      if (rom_hit(a)) begin
        chk(rom_ce && rd && !ram_ce, "R6 rom enables", {13'd0, rom_ce, rd, ram_ce}, 16'h6);
        chk(bus_out == (a ^ 16'h5A5A), "R6 rom data", bus_out, a ^ 16'h5A5A);
      end else if (ram_hit(a)) begin
        chk(bus_out == ref_ram[a[7:0]], "R8/R9 ram readback", bus_out, ref_ram[a[7:0]]);
      end else begin
        chk(!rom_ce && !ram_ce, "R7 no enables", {14'd0, rom_ce, ram_ce}, 16'h0);
      end
      phase(3'b000, 16'h0000, PH);
    end else begin
      w0 = wr_cnt;
      phase(3'b101, d, PH);
      phase(3'b110, ~d, PH);  // stall carries different data (R9)
      phase(3'b000, 16'h0000, PH);
      #1;
      chk(addr == a, tag, addr, a);
      chk((wr_cnt - w0) == (ram_hit(a) ? 1 : 0), rom_hit(a) ? "R10 no rom write" : "R8 write pulses",
          16'(wr_cnt - w0), ram_hit(a) ? 16'd1 : 16'd0);
      if (ram_hit(a)) ref_ram[a[7:0]] = d;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_ram[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(addr == 16'h0 && !oe && !wr && !rom_ce && !ram_ce && !rd, "R1 reset state", addr, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    phase(3'b000, 16'h0000, PH);

    // RAM must hold known data before glitch reads
    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][34:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // filter boundary: FILT_LEN-1 samples rejected, FILT_LEN samples accepted
    phase(3'b001, 16'h4321, 3);
    phase(3'b000, 16'h0000, PH);
    #1;
    chk(addr == 16'h1234, "R5 short pulse ignored", addr, 16'h1234);
    phase(3'b001, 16'h4321, 4);
    phase(3'b000, 16'h0000, PH);
    #1;
    chk(addr == 16'h4321, "R5 min pulse accepted", addr, 16'h4321);

    // reset in the middle of a read-data state
    phase(3'b100, 16'h1010, PH);
    phase(3'b000, 16'h0000, PH);
    phase(3'b011, 16'h0000, PH);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(addr == 16'h0 && !oe && !rom_ce && !rd, "R1 mid-run reset", addr, 16'h0);
    @(negedge clk);
    bctl = 3'b000;
    rst_n = 1'b1;
    phase(3'b000, 16'h0000, PH);
    finish_run();
  end
endmodule